// File: doc/BRIEF.md
# UART Receive Queue with Trigger Level and Character Timeout

This block holds received characters between a serial deserializer and the host in a 16-style UART. Each character or break event from the deserializer enters a 16-entry first-in first-out store. The host reads characters one at a time and writes a control byte. The control byte turns queueing on or off, empties the store, and picks the occupancy at which the receive interrupt logic should act. The block reports the occupancy, the chosen trigger level, and the data-ready, overrun and break flags. It also reports a timeout flag. The interrupt priority logic outside the block combines these outputs.

The timeout flag tells the host that a few characters are sitting below the trigger level and the line has gone quiet. A timer counts bit-period ticks while the queue holds data and nothing moves. The length of one character in bit periods is derived from the frame format the host has set. When queueing is off, one holding register stands in for the store. In that mode a new character overwrites an unread one and flags an overrun.

Top module: `uart_rxq`

## Requirements
- R1: After reset, queueing is off, occupancy is 0, the trigger level reads 1, and the data-ready, overrun, break and timeout flags are all 0.
- R2: A control write stores bits 7:6 as the trigger select, decoded 00→1, 01→4, 10→8, 11→14 on `trig_level`. Control bit 0 turns queueing on (1) or off (0), and `fifo_on` shows it.
- R3: With queueing on, reads return characters oldest first. A character arrival and a read in the same cycle are both honoured, even when the store is full, and the occupancy is then unchanged.
- R4: A character that arrives when the store is full and no read happens that cycle is discarded. The stored characters are kept and the overrun flag is set.
- R5: A break event enters a 0x00 character and sets the break flag. Data-ready is set whenever the break flag is set.
- R6: A read from an empty store returns 0x00. With queueing on, data-ready equals "occupancy non-zero". The break flag clears in the cycle the store becomes empty.
- R7: The timeout flag sets once the store has held data for 4 character times of bit ticks with no arrival and no read. An arrival, or a read that leaves data, restarts the count. A tick in a restart cycle is not counted. Any data read with queueing on clears the flag.
- R8: One character time in bit ticks is 1 + (5 + `frm_wlen`) + `frm_par_en` + (`frm_stop2` ? 2 : 1). That gives a timeout of 28 ticks for the shortest frame and 48 for the longest.
- R9: A control write with bit 1 set, or one that changes bit 0, empties the store. It clears data-ready, break and timeout and discards any arrival in that cycle. The overrun flag is untouched.
- R10: A status read (`lsr_rd`) clears the overrun and break flags, unless a new overrun or break sets them in the same cycle.
- R11: With queueing off, arrivals go into one holding register, and a read returns that register. An arrival while data-ready is set, with no read in that cycle, overwrites it and sets overrun. A read clears data-ready and break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Deserializer delivers a character or break this cycle |
| rx_brk | input | 1 | Qualifies `rx_valid` as a break event |
| rx_byte | input | DATA_W | Received character |
| frm_wlen | input | 2 | Data bits minus 5 |
| frm_par_en | input | 1 | Parity bit present in the frame |
| frm_stop2 | input | 1 | Two stop bits |
| bit_tick | input | 1 | One pulse per bit period |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte: bit 0 enable, bit 1 empty, bits 7:6 trigger select |
| rbr_rd | input | 1 | Host character read strobe |
| rbr_data | output | DATA_W | Character returned for the read in this cycle |
| lsr_rd | input | 1 | Host status read strobe |
| fifo_level | output | LVLW | Store occupancy |
| trig_level | output | 4 | Decoded trigger level |
| fifo_on | output | 1 | Queueing is enabled |
| data_ready | output | 1 | Unread data present |
| overrun | output | 1 | A character was lost |
| brk_flag | output | 1 | A break was received |
| tmo_pend | output | 1 | Character timeout pending |

## Verification
The bench fills the store to 16 and sends one more character. A design that overwrote the oldest entry, or wrapped the write pointer, would return the wrong read order and fail to set overrun. It issues an arrival and a read together on a full store. A design that ranked overrun above the read would lose a character or raise a false overrun. It runs the timeout probe at the shortest and longest frame formats, with and without a restarting read. An off-by-one tick count, or a design that restarted only on arrivals, would raise the flag a tick early or late. It also covers enable toggling, break into a full store, and the overwrite rule with queueing off, where a missing flush or a stale data-ready shows up as wrong flags.

// File: rtl/uart_rxq_pkg.sv
`timescale 1ns/1ps
package uart_rxq_pkg;
   // control byte field positions (host software decodes these)
   localparam int CTL_EN_BIT    = 0;
   localparam int CTL_FLUSH_BIT = 1;
   localparam int CTL_TRIG_LSB  = 6;
   localparam int MAX_FRAME     = 12;

   function automatic logic [3:0] frame_bits(input logic [1:0] wlen,
                                             input logic par_en,
                                             input logic stop2);
      return 4'd1 + (4'd5 + {2'b00, wlen}) + {3'b000, par_en} + (stop2 ? 4'd2 : 4'd1);
   endfunction

   function automatic logic [3:0] trig_decode(input logic [1:0] sel);
      case (sel)
         2'b00:   return 4'd1;
         2'b01:   return 4'd4;
         2'b10:   return 4'd8;
         default: return 4'd14;
      endcase
   endfunction
endpackage

// File: rtl/uart_rxq_store.sv
`timescale 1ns/1ps
module uart_rxq_store #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8,
   localparam int PTRW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LVLW  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              push,
   input  logic              pop,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] head,
   output logic [LVLW-1:0]   level,
   output logic              full,
   output logic              empty
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTRW-1:0]   wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [LVLW-1:0]   level_q;

   generate
      if ((1 << PTRW) == DEPTH) begin : g_pow2_wrap
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_mod_wrap
         assign wr_nxt = (wr_ptr == PTRW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTRW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         level_q <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   level_q <= level_q + 1'b1;
            2'b01:   level_q <= level_q - 1'b1;
            default: level_q <= level_q;
         endcase
      end
   end

   assign head  = mem[rd_ptr];
   assign level = level_q;
   assign full  = (level_q == LVLW'(DEPTH));
   assign empty = (level_q == '0);

   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      level_q <= LVLW'(DEPTH));                                            // R4
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);                                                     // R6
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |-> !full);                                           // R4
endmodule

// File: rtl/uart_rxq_timer.sv
`timescale 1ns/1ps
module uart_rxq_timer #(
   parameter int LIMW = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            rd_clear,
   input  logic            restart,
   input  logic            armed,
   input  logic            tick,
   input  logic [LIMW-1:0] limit,
   output logic            pend
);
   logic [LIMW-1:0] cnt_q;
   logic            pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
      end else if (rd_clear) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
      end else if (restart || !armed) begin
         cnt_q  <= '0;
      end else if (tick && !pend_q) begin
         if (cnt_q + LIMW'(1) >= limit) begin
            cnt_q  <= '0;
            pend_q <= 1'b1;
         end else begin
            cnt_q  <= cnt_q + LIMW'(1);
         end
      end
   end

   assign pend = pend_q;

   AST_TMO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past(armed));                                     // R7
   AST_TMO_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clear |=> !pend_q);                                               // R7
endmodule

// File: rtl/uart_rxq.sv
`timescale 1ns/1ps
module uart_rxq
   import uart_rxq_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int DATA_W    = 8,
   parameter int TMO_CHARS = 4,
   localparam int LVLW     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic              rx_brk,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic [1:0]        frm_wlen,
   input  logic              frm_par_en,
   input  logic              frm_stop2,
   input  logic              bit_tick,
   input  logic              ctl_wr,
   input  logic [7:0]        ctl_wdata,
   input  logic              rbr_rd,
   output logic [DATA_W-1:0] rbr_data,
   input  logic              lsr_rd,
   output logic [LVLW-1:0]   fifo_level,
   output logic [3:0]        trig_level,
   output logic              fifo_on,
   output logic              data_ready,
   output logic              overrun,
   output logic              brk_flag,
   output logic              tmo_pend
);
   localparam int LIMW = $clog2(TMO_CHARS * MAX_FRAME + 1);

   generate
      if (DEPTH < 14) begin : g_bad_depth
         $error("uart_rxq: DEPTH must reach the highest trigger level");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("uart_rxq: DATA_W must be positive");
      end
      if (TMO_CHARS < 1) begin : g_bad_tmo
         $error("uart_rxq: TMO_CHARS must be positive");
      end
   endgenerate

   logic              fifo_en_q, hold_dr_q, ovr_q, brk_q;
   logic [1:0]        trig_sel_q;
   logic [DATA_W-1:0] hold_q, head, ev_data;
   logic              flush, ev, f_pop, f_push, f_drop, f_empties;
   logic              st_full, st_empty, set_ovr, set_brk, clr_brk;
   logic [LIMW-1:0]   tmo_limit;
   logic              unused_ctl;

   assign unused_ctl = ^ctl_wdata[5:2];

   assign flush   = ctl_wr && (ctl_wdata[CTL_FLUSH_BIT] || (ctl_wdata[CTL_EN_BIT] != fifo_en_q));
   assign ev      = rx_valid && !flush;
   assign ev_data = rx_brk ? '0 : rx_byte;

   assign f_pop     = fifo_en_q && rbr_rd && !st_empty && !flush;
   assign f_push    = fifo_en_q && ev && (!st_full || f_pop);
   assign f_drop    = fifo_en_q && ev && st_full && !f_pop;
   assign f_empties = f_pop && !f_push && (fifo_level == LVLW'(1));

   assign set_ovr = f_drop || (!fifo_en_q && ev && hold_dr_q && !rbr_rd);
   assign set_brk = ev && rx_brk;
   assign clr_brk = flush || lsr_rd || f_empties || (!fifo_en_q && rbr_rd);

   uart_rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n), .clr(flush), .push(f_push), .pop(f_pop),
      .din(ev_data), .head(head), .level(fifo_level),
      .full(st_full), .empty(st_empty)
   );

   assign tmo_limit = LIMW'(TMO_CHARS * int'(frame_bits(frm_wlen, frm_par_en, frm_stop2)));

   uart_rxq_timer #(.LIMW(LIMW)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr(flush),
      .rd_clear(fifo_en_q && rbr_rd && !flush),
      .restart(f_push), .armed(!st_empty), .tick(bit_tick),
      .limit(tmo_limit), .pend(tmo_pend)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fifo_en_q  <= 1'b0;
         trig_sel_q <= 2'b00;
         hold_q     <= '0;
         hold_dr_q  <= 1'b0;
         ovr_q      <= 1'b0;
         brk_q      <= 1'b0;
      end else begin
         if (ctl_wr) begin
            fifo_en_q  <= ctl_wdata[CTL_EN_BIT];
            trig_sel_q <= ctl_wdata[CTL_TRIG_LSB +: 2];
         end
         if (!fifo_en_q && ev) begin
            hold_q    <= ev_data;
            hold_dr_q <= 1'b1;
         end else if (flush || (!fifo_en_q && rbr_rd)) begin
            hold_dr_q <= 1'b0;
         end
         if (set_ovr)     ovr_q <= 1'b1;
         else if (lsr_rd) ovr_q <= 1'b0;
         if (set_brk)      brk_q <= 1'b1;
         else if (clr_brk) brk_q <= 1'b0;
      end
   end

   assign rbr_data   = fifo_en_q ? (st_empty ? '0 : head) : hold_q;
   assign data_ready = fifo_en_q ? !st_empty : hold_dr_q;
   assign trig_level = trig_decode(trig_sel_q);
   assign fifo_on    = fifo_en_q;
   assign overrun    = ovr_q;
   assign brk_flag   = brk_q;

   AST_BRK_WITH_DR: assert property (@(posedge clk) disable iff (!rst_n)
      brk_flag |-> data_ready);                                            // R5
   AST_LSR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && !rx_valid) |=> (!overrun && !brk_flag));                  // R10
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (fifo_level == '0 && !tmo_pend && !data_ready));           // R9
   AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      f_drop |=> (fifo_level == LVLW'(DEPTH) && overrun));                 // R4
   AST_HOLD_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en_q && ev && hold_dr_q && !rbr_rd) |=> (overrun && data_ready)); // R11
endmodule

// File: tb/tb_uart_rxq.sv
`timescale 1ns/1ps
module tb_uart_rxq;
   localparam int DEPTH = 16;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       rx_valid = 0, rx_brk = 0, bit_tick = 0, ctl_wr = 0, rbr_rd = 0, lsr_rd = 0;
   logic [7:0] rx_byte = 0, ctl_wdata = 0, rbr_data;
   logic [1:0] frm_wlen = 0;
   logic       frm_par_en = 0, frm_stop2 = 0;
   logic [4:0] fifo_level;
   logic [3:0] trig_level;
   logic       fifo_on, data_ready, overrun, brk_flag, tmo_pend;

   int n_chk = 0, n_bad = 0;

   // model state
   logic [7:0] mq[$];
   bit         men = 0, mdr_h = 0, mov = 0, mbi = 0, mpend = 0;
   bit [1:0]   mtrig = 0;
   logic [7:0] mhold = 0;
   int         mcnt = 0;

   always #10 clk = ~clk; // 50 MHz

   uart_rxq dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_brk(rx_brk), .rx_byte(rx_byte),
      .frm_wlen(frm_wlen), .frm_par_en(frm_par_en), .frm_stop2(frm_stop2),
      .bit_tick(bit_tick), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .rbr_rd(rbr_rd),
      .rbr_data(rbr_data), .lsr_rd(lsr_rd), .fifo_level(fifo_level), .trig_level(trig_level),
      .fifo_on(fifo_on), .data_ready(data_ready), .overrun(overrun), .brk_flag(brk_flag),
      .tmo_pend(tmo_pend)
   );

   function automatic int frame_len(input int w, input int p, input int s);
      return 1 + 5 + w + p + (s != 0 ? 2 : 1);
   endfunction

   function automatic int trig_of(input bit [1:0] sel);
      case (sel)
         2'b00: return 1;
         2'b01: return 4;
         2'b10: return 8;
         default: return 14;
      endcase
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model(input bit v, input bit b, input logic [7:0] d, input bit rd,
                        input bit lsr, input bit cw, input logic [7:0] cwd, input bit tk);
      int  lvl0 = mq.size();
      int  lim  = 4 * frame_len(frm_wlen, frm_par_en, frm_stop2);
      bit  flush = cw && (cwd[1] || (cwd[0] != men));
      bit  ev = v && !flush;
      logic [7:0] ed = b ? 8'h00 : d;
      bit  pop  = men && rd && lvl0 > 0 && !flush;
      bit  full = (lvl0 == DEPTH);
      bit  push = men && ev && (!full || pop);
      bit  drop = men && ev && full && !pop;
      bit  setov = drop || (!men && ev && mdr_h && !rd);
      bit  empties = pop && !push && lvl0 == 1;
      if (flush) begin mcnt = 0; mpend = 0; end
      else if (men && rd) begin mcnt = 0; mpend = 0; end
      else if (push || lvl0 == 0) mcnt = 0;
      else if (tk && !mpend) begin
         if (mcnt + 1 >= lim) begin mpend = 1; mcnt = 0; end
         else mcnt++;
      end
      if (flush) mq.delete();
      else begin
         if (pop) void'(mq.pop_front());
         if (push) mq.push_back(ed);
      end
      if (ev && b) mbi = 1;
      else if (flush || lsr || empties || (!men && rd)) mbi = 0;
      if (setov) mov = 1;
      else if (lsr) mov = 0;
      if (!men && ev) begin mhold = ed; mdr_h = 1; end
      else if (flush || (!men && rd)) mdr_h = 0;
      if (cw) begin men = cwd[0]; mtrig = cwd[7:6]; end
   endtask

   task automatic compare_all();
      chk("R3 occupancy", fifo_level, mq.size());
      chk("R2 trigger level", trig_level, trig_of(mtrig));
      chk("R2 enable", fifo_on, men);
      chk("R6 data ready", data_ready, men ? (mq.size() != 0) : mdr_h);
      chk("R4 overrun", overrun, mov);
      chk("R5 break", brk_flag, mbi);
      chk("R7 timeout", tmo_pend, mpend);
   endtask

   task automatic step(input bit v, input bit b, input logic [7:0] d, input bit rd,
                       input bit lsr, input bit cw, input logic [7:0] cwd, input bit tk);
      rx_valid = v; rx_brk = b; rx_byte = d; rbr_rd = rd; lsr_rd = lsr;
      ctl_wr = cw; ctl_wdata = cwd; bit_tick = tk;
      #1;
      if (rd) begin
         if (men) chk(mq.size() == 0 ? "R6 empty read" : "R3 read order", rbr_data,
                      mq.size() == 0 ? 0 : mq[0]);
         else chk("R11 holding read", rbr_data, mhold);
      end
      @(posedge clk);
      model(v, b, d, rd, lsr, cw, cwd, tk);
      @(negedge clk);
      compare_all();
   endtask

   task automatic push_b(input logic [7:0] d); step(1,0,d,0,0,0,8'h00,0); endtask
   task automatic pop_b();  step(0,0,8'h00,1,0,0,8'h00,0); endtask
   task automatic ctl(input logic [7:0] c); step(0,0,8'h00,0,0,1,c,0); endtask
   task automatic tick_n(input int n);
      for (int i = 0; i < n; i++) step(0,0,8'h00,0,0,0,8'h00,1);
   endtask

   task automatic tmo_probe(input int w, input int p, input int s);
      int lim;
      frm_wlen = 2'(w); frm_par_en = 1'(p); frm_stop2 = 1'(s);
      lim = 4 * frame_len(w, p, s);
      ctl(8'h03);
      push_b(8'h5A);
      tick_n(lim - 1);
      chk("R8 no timeout one tick early", tmo_pend, 0);
      tick_n(1);
      chk("R8 timeout after four characters", tmo_pend, 1);
      pop_b();
      chk("R7 read clears timeout", tmo_pend, 0);
      // restart on a read that leaves data
      push_b(8'h11); push_b(8'h22);
      tick_n(lim - 1);
      pop_b();
      tick_n(lim - 1);
      chk("R7 read restarted count", tmo_pend, 0);
      tick_n(1);
      chk("R7 timeout after restart", tmo_pend, 1);
   endtask

   initial begin
      #(20 * 200000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset occupancy", fifo_level, 0);
      chk("R1 reset trigger", trig_level, 1);
      chk("R1 reset enable", fifo_on, 0);
      chk("R1 reset flags", {data_ready, overrun, brk_flag, tmo_pend}, 0);

      // trigger decode
      ctl(8'h41); chk("R2 select 01", trig_level, 4);
      ctl(8'h81); chk("R2 select 10", trig_level, 8);
      ctl(8'hC1); chk("R2 select 11", trig_level, 14);

      // fill, overrun, drain
      for (int i = 0; i < DEPTH; i++) push_b(8'(8'h30 + i));
      chk("R3 full occupancy", fifo_level, DEPTH);
      push_b(8'hEE);
      chk("R4 drop keeps occupancy", fifo_level, DEPTH);
      chk("R4 overrun set", overrun, 1);
      step(1,0,8'h77,1,0,0,8'h00,0);
      chk("R3 push and pop on full", fifo_level, DEPTH);
      for (int i = 0; i < DEPTH; i++) pop_b();
      chk("R6 empty data ready", data_ready, 0);
      pop_b();
      step(0,0,8'h00,0,1,0,8'h00,0);
      chk("R10 status read clears overrun", overrun, 0);

      // break
      step(1,1,8'hAB,0,0,0,8'h00,0);
      chk("R5 break flag", brk_flag, 1);
      chk("R5 break data ready", data_ready, 1);
      pop_b();
      chk("R6 break cleared on empty", brk_flag, 0);
      step(1,1,8'h00,0,0,0,8'h00,0);
      step(0,0,8'h00,0,1,0,8'h00,0);
      chk("R10 status read clears break", brk_flag, 0);

      // flush by bit 1 and by toggle
      push_b(8'h01); push_b(8'h02);
      ctl(8'h03);
      chk("R9 flush empties", fifo_level, 0);
      push_b(8'h03);
      ctl(8'h00);
      chk("R9 toggle empties", data_ready, 0);

      // holding register mode
      push_b(8'hA1); push_b(8'hB2);
      chk("R11 overwrite sets overrun", overrun, 1);
      pop_b();
      chk("R11 read clears data ready", data_ready, 0);
      step(0,0,8'h00,0,1,0,8'h00,0);

      tmo_probe(0, 0, 0);
      tmo_probe(3, 1, 1);

      // constrained random phases
      for (int ph = 0; ph < 15; ph++) begin
         int prx, prd;
         frm_wlen = 2'($urandom_range(0, 3));
         frm_par_en = 1'($urandom_range(0, 1));
         frm_stop2 = 1'($urandom_range(0, 1));
         ctl({2'($urandom_range(0, 3)), 5'd0, 1'($urandom_range(0, 5) != 0)});
         case (ph % 3)
            0: begin prx = 40; prd = 10; end
            1: begin prx = 10; prd = 50; end
            default: begin prx = 2; prd = 2; end
         endcase
         for (int i = 0; i < 400; i++) begin
            bit v  = $urandom_range(0, 99) < prx;
            bit b  = $urandom_range(0, 19) == 0;
            bit rd = $urandom_range(0, 99) < prd;
            bit ls = $urandom_range(0, 9) == 0;
            bit cw = $urandom_range(0, 199) == 0;
            logic [7:0] cwd = 8'($urandom_range(0, 255));
            step(v, b, 8'($urandom_range(0, 255)), rd, ls, cw, cwd, 1'($urandom_range(0, 1)));
         end
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule